// File: doc/BRIEF.md
# Speculative Load Tracking Buffer

This block keeps a record of loads that an out-of-order core has issued ahead of the point where the memory-ordering rules would allow them. Each slot records the load's cache-line address, whether the load counts as an acquire, whether it has completed, and whether it still waits on an older store that has not yet performed. The core allocates slots in program order and retires them in order from the head. The block tells the core when the head slot may retire.

A snoop port carries coherence events from the cache. An invalidation, an update or a line replacement that hits a tracked line means a speculation has failed. If a completed load is hit, the block requests a squash from the oldest hit slot onward. If only loads that have not completed are hit, the block requests a reissue of those loads and leaves younger work alone. A mode input picks sequential consistency, where every load is an acquire, or release consistency, where only uncached loads are. The pipeline answers a squash with a flush that drops every slot from a given index to the tail.

Top module: `spec_load_buffer`

## Requirements
- R1: Each accepted allocation takes the slot named by `alloc_idx_o` and advances it by one, modulo DEPTH. `full_o` is 1 exactly when DEPTH slots are occupied. While `full_o` is 1, an allocation request is ignored.
- R2: The acquire flag is fixed when a slot is allocated. With `mode_i`=0 (sequential) it is always set. With `mode_i`=1 (release) it is set only when `alloc_uncached_i`=1.
- R3: `retire_ready_o` is 1 exactly when three things hold: the head slot is occupied, its store tag is null, and it is either not an acquire or already done. `done_valid_i` marks the occupied slot `done_idx_i` as done. `retire_i` with `retire_ready_o`=1 frees the head slot, and the next slot becomes the head.
- R4: `st_perf_valid_i` with tag `st_perf_tag_i` nulls every occupied slot's pending tag equal to it in that cycle. This includes a slot allocated in the same cycle with that tag.
- R5: A snoop matches a slot when `snoop_kind_i` is 0 (invalidate), 1 (update) or 2 (replace) and address bits above LINE_OFF_W equal the slot's. Offset bits never matter. Kind 3 (shared read) never triggers recovery.
- R6: When at least one matching slot is done, `squash_o` is 1 in the cycle after the snoop. `squash_idx_o` then names the oldest matching slot, counted from the head.
- R7: When slots match but none is done, `reissue_o` is 1 in the cycle after the snoop and `reissue_mask_o` has one bit set per matching slot. `squash_o` stays 0. The two outputs are never 1 together.
- R8: `flush_i` naming an occupied slot frees that slot and every younger one in one cycle, and `alloc_idx_o` becomes `flush_idx_i`. In that cycle, allocation and retirement are ignored. A flush naming a free slot has no effect.
- R9: After reset the buffer is empty: `alloc_idx_o`=0, and `full_o`, `retire_ready_o`, `squash_o`, `reissue_o` and `reissue_mask_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 sequential, 1 release consistency |
| alloc_valid_i | input | 1 | Allocate a slot for a new load |
| alloc_addr_i | input | ADDR_W | Load byte address |
| alloc_uncached_i | input | 1 | Load targets an uncached location |
| alloc_stag_vld_i | input | 1 | Load waits on an older store |
| alloc_stag_i | input | STAG_W | Tag of that store |
| alloc_idx_o | output | IDX_W | Slot the next allocation takes |
| full_o | output | 1 | All slots occupied |
| done_valid_i | input | 1 | A load has completed |
| done_idx_i | input | IDX_W | Slot of the completed load |
| st_perf_valid_i | input | 1 | A store has performed |
| st_perf_tag_i | input | STAG_W | Tag of the performed store |
| snoop_valid_i | input | 1 | Coherence event present |
| snoop_kind_i | input | 2 | 0 inval, 1 update, 2 replace, 3 shared |
| snoop_addr_i | input | ADDR_W | Snooped address |
| retire_i | input | 1 | Core retires the head load |
| retire_ready_o | output | 1 | Head load may retire |
| flush_i | input | 1 | Pipeline flush |
| flush_idx_i | input | IDX_W | Oldest slot to drop |
| squash_o | output | 1 | Squash request |
| squash_idx_o | output | IDX_W | Squash point |
| reissue_o | output | 1 | Reissue request |
| reissue_mask_o | output | DEPTH | Slots to reissue |

## Verification
Checks that hold on every cycle are these. A shared-read snoop, or a cycle with no snoop, is followed by no recovery request. Squash and reissue never occur together. A full buffer holds its allocation slot unless a flush arrives. A flush at the head leaves the buffer empty. Only the bench scenarios can show the rest: the acquire marking in each mode, tag nulling when a store performs in the same cycle as an allocation, selection of the oldest hit slot across wrap-around, and the exact reissue masks. For those, a reference queue driven by random snoops, completions, store performs and flushes in both modes is compared with the outputs on every cycle.

// File: rtl/slb_pkg.sv
package slb_pkg;
  typedef enum logic [1:0] {
    SNP_INVAL   = 2'd0,
    SNP_UPDATE  = 2'd1,
    SNP_REPLACE = 2'd2,
    SNP_SHARED  = 2'd3
  } snoop_kind_e;

  typedef enum logic {
    MODE_SC = 1'b0,
    MODE_RC = 1'b1
  } cons_mode_e;

  function automatic logic snoop_kills(input snoop_kind_e kind);
    return kind != SNP_SHARED;
  endfunction
endpackage

// File: rtl/slb_ptr_ctrl.sv
module slb_ptr_ctrl #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_fire_i,
  input  logic             retire_fire_i,
  input  logic             flush_fire_i,
  input  logic [IDX_W-1:0] flush_idx_i,
  input  logic [DEPTH-1:0] valid_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic             full_o,
  output logic [DEPTH-1:0] kill_o
);
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] flush_ofs;

  assign flush_ofs = flush_idx_i - head_q;

  // age offset relative to head decides which slots are younger than the flush point
  for (genvar i = 0; i < DEPTH; i++) begin : g_kill
    logic [IDX_W-1:0] ofs;
    assign ofs       = IDX_W'(i) - head_q;
    assign kill_o[i] = flush_fire_i && valid_i[i] && (ofs >= flush_ofs);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (flush_fire_i) begin
      tail_q <= flush_idx_i;
      cnt_q  <= CNT_W'(flush_ofs);
    end else begin
      if (alloc_fire_i)  tail_q <= tail_q + 1'b1;
      if (retire_fire_i) head_q <= head_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(alloc_fire_i) - CNT_W'(retire_fire_i);
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign full_o = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/slb_entry_array.sv
module slb_entry_array #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int LINE_W = 26,
  parameter int STAG_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_fire_i,
  input  logic [IDX_W-1:0]  alloc_slot_i,
  input  logic [LINE_W-1:0] alloc_line_i,
  input  logic              alloc_acq_i,
  input  logic              alloc_stag_vld_i,
  input  logic [STAG_W-1:0] alloc_stag_i,
  input  logic              done_valid_i,
  input  logic [IDX_W-1:0]  done_idx_i,
  input  logic              st_perf_valid_i,
  input  logic [STAG_W-1:0] st_perf_tag_i,
  input  logic [DEPTH-1:0]  kill_i,
  input  logic              retire_fire_i,
  input  logic [IDX_W-1:0]  head_i,
  output logic [DEPTH-1:0]  valid_o,
  output logic [DEPTH-1:0]  acq_o,
  output logic [DEPTH-1:0]  done_o,
  output logic [DEPTH-1:0]  stag_vld_o,
  output logic [LINE_W-1:0] line_o [DEPTH]
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic              v_q, acq_q, done_q, sv_q;
    logic [LINE_W-1:0] line_q;
    logic [STAG_W-1:0] st_q;
    logic              free_me, wr_me;

    assign free_me = kill_i[i] || (retire_fire_i && head_i == IDX_W'(i));
    assign wr_me   = alloc_fire_i && alloc_slot_i == IDX_W'(i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q    <= 1'b0;
        acq_q  <= 1'b0;
        done_q <= 1'b0;
        sv_q   <= 1'b0;
        line_q <= '0;
        st_q   <= '0;
      end else if (free_me) begin
        v_q <= 1'b0;
      end else if (wr_me) begin
        v_q    <= 1'b1;
        acq_q  <= alloc_acq_i;
        done_q <= 1'b0;
        sv_q   <= alloc_stag_vld_i;
        line_q <= alloc_line_i;
        st_q   <= alloc_stag_i;
      end else if (v_q) begin
        if (done_valid_i && done_idx_i == IDX_W'(i)) done_q <= 1'b1;
        if (st_perf_valid_i && sv_q && st_q == st_perf_tag_i) sv_q <= 1'b0;
      end
    end

    assign valid_o[i]    = v_q;
    assign acq_o[i]      = acq_q;
    assign done_o[i]     = done_q;
    assign stag_vld_o[i] = sv_q;
    assign line_o[i]     = line_q;
  end
endmodule

// File: rtl/slb_snoop_unit.sv
module slb_snoop_unit
  import slb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int LINE_W = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              snoop_valid_i,
  input  snoop_kind_e       snoop_kind_i,
  input  logic [LINE_W-1:0] snoop_line_i,
  input  logic [DEPTH-1:0]  valid_i,
  input  logic [DEPTH-1:0]  done_i,
  input  logic [LINE_W-1:0] line_i [DEPTH],
  input  logic [IDX_W-1:0]  head_i,
  output logic              squash_o,
  output logic [IDX_W-1:0]  squash_idx_o,
  output logic              reissue_o,
  output logic [DEPTH-1:0]  reissue_mask_o
);
  logic             kill_kind;
  logic [DEPTH-1:0] hit, hit_rot;
  logic [IDX_W-1:0] first_ofs, oldest;
  logic             any_hit, any_done;

  assign kill_kind = snoop_valid_i && snoop_kills(snoop_kind_i);

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = kill_kind && valid_i[i] && (line_i[i] == snoop_line_i);
  end

  // rotate so bit 0 is the head: lowest set bit is the oldest hit
  for (genvar k = 0; k < DEPTH; k++) begin : g_rot
    logic [IDX_W-1:0] pos;
    assign pos        = IDX_W'(k) + head_i;
    assign hit_rot[k] = hit[pos];
  end

  always_comb begin
    first_ofs = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (hit_rot[k]) first_ofs = IDX_W'(k);
    end
  end

  assign oldest   = head_i + first_ofs;
  assign any_hit  = |hit;
  assign any_done = |(hit & done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      squash_o       <= 1'b0;
      squash_idx_o   <= '0;
      reissue_o      <= 1'b0;
      reissue_mask_o <= '0;
    end else begin
      squash_o       <= any_done;
      squash_idx_o   <= any_done ? oldest : '0;
      reissue_o      <= any_hit && !any_done;
      reissue_mask_o <= any_done ? '0 : hit;
    end
  end
endmodule

// File: rtl/spec_load_buffer.sv
module spec_load_buffer
  import slb_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int ADDR_W     = 32,
  parameter int LINE_OFF_W = 6,
  parameter int STAG_W     = 4,
  localparam int IDX_W     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              alloc_valid_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic              alloc_uncached_i,
  input  logic              alloc_stag_vld_i,
  input  logic [STAG_W-1:0] alloc_stag_i,
  output logic [IDX_W-1:0]  alloc_idx_o,
  output logic              full_o,
  input  logic              done_valid_i,
  input  logic [IDX_W-1:0]  done_idx_i,
  input  logic              st_perf_valid_i,
  input  logic [STAG_W-1:0] st_perf_tag_i,
  input  logic              snoop_valid_i,
  input  logic [1:0]        snoop_kind_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  input  logic              retire_i,
  output logic              retire_ready_o,
  input  logic              flush_i,
  input  logic [IDX_W-1:0]  flush_idx_i,
  output logic              squash_o,
  output logic [IDX_W-1:0]  squash_idx_o,
  output logic              reissue_o,
  output logic [DEPTH-1:0]  reissue_mask_o
);
  localparam int CNT_W  = IDX_W + 1;
  localparam int LINE_W = ADDR_W - LINE_OFF_W;

  cons_mode_e        mode;
  logic [IDX_W-1:0]  head_idx, tail_idx;
  logic [DEPTH-1:0]  ent_valid, ent_acq, ent_done, ent_stag_vld, kill_vec;
  logic [LINE_W-1:0] ent_line [DEPTH];
  logic              head_valid, flush_fire, alloc_fire, retire_fire;
  logic              alloc_acq, alloc_sv;
  logic              unused_offsets;

  assign mode           = cons_mode_e'(mode_i);
  assign unused_offsets = ^{alloc_addr_i[LINE_OFF_W-1:0], snoop_addr_i[LINE_OFF_W-1:0]};

  assign head_valid     = ent_valid[head_idx];
  assign flush_fire     = flush_i && ent_valid[flush_idx_i];
  assign alloc_fire     = alloc_valid_i && !full_o && !flush_fire;
  assign retire_ready_o = head_valid && !ent_stag_vld[head_idx] &&
                          (!ent_acq[head_idx] || ent_done[head_idx]);
  assign retire_fire    = retire_i && retire_ready_o && !flush_fire;

  assign alloc_acq = (mode == MODE_SC) || alloc_uncached_i;
  // a store performing in the allocation cycle never leaves a stale tag
  assign alloc_sv  = alloc_stag_vld_i &&
                     !(st_perf_valid_i && st_perf_tag_i == alloc_stag_i);

  slb_ptr_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ptr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_fire_i (alloc_fire),
    .retire_fire_i(retire_fire),
    .flush_fire_i (flush_fire),
    .flush_idx_i  (flush_idx_i),
    .valid_i      (ent_valid),
    .head_o       (head_idx),
    .tail_o       (tail_idx),
    .full_o       (full_o),
    .kill_o       (kill_vec)
  );

  slb_entry_array #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LINE_W(LINE_W), .STAG_W(STAG_W)) u_ent (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .alloc_fire_i    (alloc_fire),
    .alloc_slot_i    (tail_idx),
    .alloc_line_i    (alloc_addr_i[ADDR_W-1:LINE_OFF_W]),
    .alloc_acq_i     (alloc_acq),
    .alloc_stag_vld_i(alloc_sv),
    .alloc_stag_i    (alloc_stag_i),
    .done_valid_i    (done_valid_i),
    .done_idx_i      (done_idx_i),
    .st_perf_valid_i (st_perf_valid_i),
    .st_perf_tag_i   (st_perf_tag_i),
    .kill_i          (kill_vec),
    .retire_fire_i   (retire_fire),
    .head_i          (head_idx),
    .valid_o         (ent_valid),
    .acq_o           (ent_acq),
    .done_o          (ent_done),
    .stag_vld_o      (ent_stag_vld),
    .line_o          (ent_line)
  );

  slb_snoop_unit #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_snp (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .snoop_valid_i (snoop_valid_i),
    .snoop_kind_i  (snoop_kind_e'(snoop_kind_i)),
    .snoop_line_i  (snoop_addr_i[ADDR_W-1:LINE_OFF_W]),
    .valid_i       (ent_valid),
    .done_i        (ent_done),
    .line_i        (ent_line),
    .head_i        (head_idx),
    .squash_o      (squash_o),
    .squash_idx_o  (squash_idx_o),
    .reissue_o     (reissue_o),
    .reissue_mask_o(reissue_mask_o)
  );

  assign alloc_idx_o = tail_idx;
endmodule

// File: rtl/slb_checker.sv
module slb_checker #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             full_o,
  input logic             flush_i,
  input logic [IDX_W-1:0] flush_idx_i,
  input logic [IDX_W-1:0] alloc_idx_o,
  input logic             retire_ready_o,
  input logic             snoop_valid_i,
  input logic [1:0]       snoop_kind_i,
  input logic             squash_o,
  input logic             reissue_o,
  input logic [DEPTH-1:0] reissue_mask_o,
  input logic [IDX_W-1:0] head_idx_i,
  input logic             head_valid_i
);
  logic unused_mask;
  assign unused_mask = ^reissue_mask_o;

  AST_FULL_HOLDS_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !flush_i) |=> $stable(alloc_idx_o)); // R1

  AST_SHARED_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_valid_i && snoop_kind_i == 2'd3) |=> (!squash_o && !reissue_o)); // R5

  AST_NO_SNOOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snoop_valid_i |=> (!squash_o && !reissue_o)); // R6

  AST_RECOVERY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(squash_o && reissue_o)); // R7

  AST_HEAD_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && head_valid_i && flush_idx_i == head_idx_i)
      |=> (!retire_ready_o && !full_o && alloc_idx_o == $past(head_idx_i))); // R8
endmodule

bind spec_load_buffer slb_checker #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_slb_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .full_o        (full_o),
  .flush_i       (flush_i),
  .flush_idx_i   (flush_idx_i),
  .alloc_idx_o   (alloc_idx_o),
  .retire_ready_o(retire_ready_o),
  .snoop_valid_i (snoop_valid_i),
  .snoop_kind_i  (snoop_kind_i),
  .squash_o      (squash_o),
  .reissue_o     (reissue_o),
  .reissue_mask_o(reissue_mask_o),
  .head_idx_i    (head_idx),
  .head_valid_i  (head_valid)
);

// File: tb/tb_spec_load_buffer.sv
module tb_spec_load_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int AW = 32;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode = 1'b0, alloc_v = 1'b0, unc = 1'b0, sv = 1'b0, dv = 1'b0, spv = 1'b0;
  logic snv = 1'b0, ret = 1'b0, flush = 1'b0;
  logic [AW-1:0] aaddr = '0, saddr = '0;
  logic [SW-1:0] st = '0, spt = '0;
  logic [2:0] didx = '0, fidx = '0;
  logic [1:0] skind = '0;
  logic [2:0] alloc_idx, sq_idx;
  logic full, ready, sq, ri;
  logic [DEPTH-1:0] rmask;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_load_buffer dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode),
    .alloc_valid_i(alloc_v), .alloc_addr_i(aaddr), .alloc_uncached_i(unc),
    .alloc_stag_vld_i(sv), .alloc_stag_i(st), .alloc_idx_o(alloc_idx), .full_o(full),
    .done_valid_i(dv), .done_idx_i(didx), .st_perf_valid_i(spv), .st_perf_tag_i(spt),
    .snoop_valid_i(snv), .snoop_kind_i(skind), .snoop_addr_i(saddr),
    .retire_i(ret), .retire_ready_o(ready), .flush_i(flush), .flush_idx_i(fidx),
    .squash_o(sq), .squash_idx_o(sq_idx), .reissue_o(ri), .reissue_mask_o(rmask)
  );

  // reference queue
  logic m_v[DEPTH], m_acq[DEPTH], m_done[DEPTH], m_sv[DEPTH];
  logic [AW-7:0] m_line[DEPTH];
  logic [SW-1:0] m_st[DEPTH];
  logic [2:0] m_head, m_tail;
  int m_cnt;
  logic e_sq, e_ri;
  logic [2:0] e_sqi;
  logic [DEPTH-1:0] e_mask;

  function automatic logic m_ready();
    return m_v[m_head] && !m_sv[m_head] && (!m_acq[m_head] || m_done[m_head]);
  endfunction

  task automatic m_reset();
    for (int i = 0; i < DEPTH; i++) begin
      m_v[i] = 1'b0; m_acq[i] = 1'b0; m_done[i] = 1'b0; m_sv[i] = 1'b0;
      m_line[i] = '0; m_st[i] = '0;
    end
    m_head = '0; m_tail = '0; m_cnt = 0;
    e_sq = 1'b0; e_ri = 1'b0; e_sqi = '0; e_mask = '0;
  endtask

  task automatic m_update();
    logic [DEPTH-1:0] hit, dn;
    logic pre_ready, pre_full, found, ffire;
    logic [2:0] j, fo;
    hit = '0; dn = '0; found = 1'b0; e_sqi = '0;
    for (int i = 0; i < DEPTH; i++) begin
      hit[i] = snv && skind != 2'd3 && m_v[i] && m_line[i] == saddr[AW-1:6];
      dn[i] = m_done[i];
    end
    for (int k = 0; k < DEPTH; k++) begin
      j = m_head + 3'(k);
      if (hit[j] && !found) begin found = 1'b1; e_sqi = j; end
    end
    e_sq = |(hit & dn);
    e_ri = (hit != 0) && !e_sq;
    e_mask = e_sq ? '0 : hit;
    if (!e_sq) e_sqi = '0;
    pre_ready = m_ready();
    pre_full = (m_cnt == DEPTH);
    ffire = flush && m_v[fidx];
    for (int i = 0; i < DEPTH; i++) begin
      if (m_v[i]) begin
        if (dv && didx == 3'(i)) m_done[i] = 1'b1;
        if (spv && m_sv[i] && m_st[i] == spt) m_sv[i] = 1'b0;
      end
    end
    if (ffire) begin
      fo = fidx - m_head;
      for (int k = 0; k < DEPTH; k++) if (3'(k) >= fo) m_v[m_head + 3'(k)] = 1'b0;
      m_tail = fidx;
      m_cnt = int'(fo);
    end else begin
      if (ret && pre_ready) begin
        m_v[m_head] = 1'b0; m_head = m_head + 3'd1; m_cnt--;
      end
      if (alloc_v && !pre_full) begin
        m_v[m_tail] = 1'b1;
        m_acq[m_tail] = (mode == 1'b0) || unc;
        m_done[m_tail] = 1'b0;
        m_sv[m_tail] = sv && !(spv && spt == st);
        m_st[m_tail] = st;
        m_line[m_tail] = aaddr[AW-1:6];
        m_tail = m_tail + 3'd1; m_cnt++;
      end
    end
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(32'(full), 32'(m_cnt == DEPTH), "R1 full_o");
    chk(32'(alloc_idx), 32'(m_tail), "R1 alloc_idx_o");
    chk(32'(ready), 32'(m_ready()), "R3 retire_ready_o");
    chk(32'(sq), 32'(e_sq), "R6 squash_o");
    chk(32'(sq_idx), 32'(e_sqi), "R6 squash_idx_o");
    chk(32'(ri), 32'(e_ri), "R7 reissue_o");
    chk(32'(rmask), 32'(e_mask), "R7 reissue_mask_o");
  endtask

  task automatic tick();
    @(posedge clk);
    m_update();
    @(negedge clk);
    compare();
    alloc_v = 1'b0; dv = 1'b0; spv = 1'b0; snv = 1'b0; ret = 1'b0; flush = 1'b0;
    sv = 1'b0; unc = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    m_reset();
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic alloc_line(input logic [3:0] line, input logic [5:0] ofs);
    alloc_v = 1'b1;
    aaddr = {22'd0, line, ofs};
  endtask

  typedef struct packed {
    logic alloc; logic unc; logic [3:0] aline; logic sv; logic [3:0] st;
    logic dv; logic [2:0] didx; logic spv; logic [3:0] spt;
    logic snv; logic [1:0] skind; logic [3:0] sline; logic ret; logic mode; logic exp_ready;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    // R2 SC acquire, R4 pending tag 2
    '{1'b1,1'b0,4'd1,1'b1,4'd2, 1'b0,3'd0, 1'b0,4'd0, 1'b0,2'd0,4'd0, 1'b0,1'b0,1'b0},
    '{1'b0,1'b0,4'd0,1'b0,4'd0, 1'b0,3'd0, 1'b1,4'd2, 1'b0,2'd0,4'd0, 1'b0,1'b0,1'b0},
    '{1'b0,1'b0,4'd0,1'b0,4'd0, 1'b1,3'd0, 1'b0,4'd0, 1'b0,2'd0,4'd0, 1'b0,1'b0,1'b1},
    '{1'b0,1'b0,4'd0,1'b0,4'd0, 1'b0,3'd0, 1'b0,4'd0, 1'b0,2'd0,4'd0, 1'b1,1'b0,1'b0},
    // R2 RC cached load is no acquire
    '{1'b1,1'b0,4'd2,1'b0,4'd0, 1'b0,3'd0, 1'b0,4'd0, 1'b0,2'd0,4'd0, 1'b0,1'b1,1'b1},
    '{1'b1,1'b1,4'd3,1'b0,4'd0, 1'b0,3'd0, 1'b0,4'd0, 1'b0,2'd0,4'd0, 1'b1,1'b1,1'b0},
    // R5 R7 invalidate hits not-done slot 2
    '{1'b0,1'b0,4'd0,1'b0,4'd0, 1'b0,3'd0, 1'b0,4'd0, 1'b1,2'd0,4'd3, 1'b0,1'b1,1'b0},
    '{1'b0,1'b0,4'd0,1'b0,4'd0, 1'b1,3'd2, 1'b0,4'd0, 1'b0,2'd0,4'd0, 1'b0,1'b1,1'b1},
    // R5 shared snoop ignored, then R6 replace on done slot
    '{1'b0,1'b0,4'd0,1'b0,4'd0, 1'b0,3'd0, 1'b0,4'd0, 1'b1,2'd3,4'd3, 1'b0,1'b1,1'b1},
    '{1'b0,1'b0,4'd0,1'b0,4'd0, 1'b0,3'd0, 1'b0,4'd0, 1'b1,2'd2,4'd3, 1'b0,1'b1,1'b1}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    do_reset();
    // R9 reset state
    chk(32'(alloc_idx), 32'd0, "R9 alloc_idx_o");
    chk(32'(full), 32'd0, "R9 full_o");
    chk(32'(ready), 32'd0, "R9 retire_ready_o");
    chk(32'({sq, ri, rmask}), 32'd0, "R9 recovery outputs");

    for (int r = 0; r < NV; r++) begin
      alloc_v = VEC[r].alloc; unc = VEC[r].unc; sv = VEC[r].sv; st = VEC[r].st;
      aaddr = {22'd0, VEC[r].aline, 6'h04};
      dv = VEC[r].dv; didx = VEC[r].didx; spv = VEC[r].spv; spt = VEC[r].spt;
      snv = VEC[r].snv; skind = VEC[r].skind; saddr = {22'd0, VEC[r].sline, 6'h3c};
      ret = VEC[r].ret; mode = VEC[r].mode;
      tick();
      chk(32'(ready), 32'(VEC[r].exp_ready), "R3 table retire_ready_o");
    end
    chk(32'({sq, sq_idx}), 32'({1'b1, 3'd2}), "R6 squash at slot 2");

    // R8 partial flush, ignored flush, head flush beating allocation
    mode = 1'b1;
    for (int k = 0; k < 3; k++) begin alloc_line(4'd4 + 4'(k), 6'h0); tick(); end
    flush = 1'b1; fidx = 3'd4; tick();
    chk(32'(alloc_idx), 32'd4, "R8 flush to slot 4");
    flush = 1'b1; fidx = 3'd6; tick();
    chk(32'(alloc_idx), 32'd4, "R8 flush of free slot ignored");
    flush = 1'b1; fidx = 3'd2; alloc_line(4'd9, 6'h0); tick();
    chk(32'({alloc_idx, ready, full}), 32'({3'd2, 1'b0, 1'b0}), "R8 head flush empties");

    // R1 fill and overflow
    for (int k = 0; k < DEPTH; k++) begin alloc_line(4'(k), 6'h0); tick(); end
    chk(32'({full, alloc_idx}), 32'({1'b1, 3'd2}), "R1 full after DEPTH allocs");
    alloc_line(4'd12, 6'h0); tick();
    chk(32'({full, alloc_idx}), 32'({1'b1, 3'd2}), "R1 alloc ignored when full");
    ret = 1'b1; tick();
    chk(32'(full), 32'd0, "R1 R3 retire frees a slot");

    // R2 acquire marking per mode
    do_reset(); mode = 1'b1; unc = 1'b1; alloc_line(4'd1, 6'h0); tick();
    chk(32'(ready), 32'd0, "R2 RC uncached is acquire");
    do_reset(); mode = 1'b1; alloc_line(4'd1, 6'h0); tick();
    chk(32'(ready), 32'd1, "R2 RC cached not acquire");
    do_reset(); mode = 1'b0; alloc_line(4'd1, 6'h0); tick();
    chk(32'(ready), 32'd0, "R2 SC always acquire");

    // R4 store perform in allocation cycle
    do_reset(); mode = 1'b1; alloc_line(4'd1, 6'h0); sv = 1'b1; st = 4'd5;
    spv = 1'b1; spt = 4'd5; tick();
    chk(32'(ready), 32'd1, "R4 same-cycle perform nulls tag");
    do_reset(); mode = 1'b1; alloc_line(4'd1, 6'h0); sv = 1'b1; st = 4'd5;
    spv = 1'b1; spt = 4'd6; tick();
    chk(32'(ready), 32'd0, "R4 other tag keeps load pending");

    // R5 offset masking and line mismatch
    do_reset(); alloc_line(4'd7, 6'h00); tick();
    snv = 1'b1; skind = 2'd0; saddr = {22'd0, 4'd7, 6'h3f}; tick();
    chk(32'({ri, rmask}), 32'({1'b1, 8'h01}), "R5 offset bits ignored");
    snv = 1'b1; skind = 2'd1; saddr = {22'd0, 4'd8, 6'h00}; tick();
    chk(32'({sq, ri}), 32'd0, "R5 other line no match");

    // R6 oldest matching slot chosen even when not done
    do_reset(); alloc_line(4'd1, 6'h0); tick(); alloc_line(4'd2, 6'h0); tick();
    alloc_line(4'd1, 6'h0); tick(); dv = 1'b1; didx = 3'd2; tick();
    snv = 1'b1; skind = 2'd1; saddr = {22'd0, 4'd1, 6'h0}; tick();
    chk(32'({sq, sq_idx, ri}), 32'({1'b1, 3'd0, 1'b0}), "R6 oldest match is squash point");

    // R7 all not-done matches reissued
    do_reset(); alloc_line(4'd3, 6'h0); tick(); alloc_line(4'd3, 6'h8); tick();
    snv = 1'b1; skind = 2'd2; saddr = {22'd0, 4'd3, 6'h0}; tick();
    chk(32'({sq, ri, rmask}), 32'({1'b0, 1'b1, 8'h03}), "R7 reissue mask");

    // random phase against the reference queue, both modes
    do_reset();
    for (int c = 0; c < 4000; c++) begin
      mode = ((c / 500) % 2) == 1;
      alloc_v = ($urandom % 2) == 0;
      unc = ($urandom % 2) == 0;
      aaddr = {22'd0, 4'($urandom % 4), 6'($urandom)};
      sv = ($urandom % 5) < 2; st = 4'($urandom % 8);
      dv = ($urandom % 5) < 2; didx = 3'($urandom);
      spv = ($urandom % 10) < 3; spt = 4'($urandom % 8);
      snv = ($urandom % 5) == 0; skind = 2'($urandom);
      saddr = {22'd0, 4'($urandom % 4), 6'($urandom)};
      ret = ($urandom % 2) == 0;
      if (sq) begin flush = 1'b1; fidx = sq_idx; end
      else begin flush = ($urandom % 32) == 0; fidx = 3'($urandom); end
      tick();
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule